// File: doc/BRIEF.md
# Retired-Op Sampling Unit

This unit picks one operation out of the dispatch stream, follows it through execution, and publishes a sample record only if that operation retires. A period counter decides when the next operation is picked. In cycle mode it counts enabled clock cycles. In dispatch mode it counts dispatched operations. Once the period has run out, the next dispatched operation becomes the tracked one. Its tag, instruction address, timestamp and process identifier are captured at that point.

While the tracked operation is in flight, execution event flags that carry its tag are ORed into the record. A retire strobe for its tag completes the record, raises `smpValid` and pulses `irq` for one cycle. A flush strobe for its tag throws the operation away silently and restarts the count. Only one operation is followed at a time. After a sample has been published the unit does nothing more until software clears the sample.

Top module: `op_retire_sampler`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `smpValid` and `irq` are 0 and no operation is tracked.
- R2: With mode 0 (cycle mode), each enabled cycle counts one. Once `period` cycles have been counted, the first dispatch sampled on a later clock edge is tracked. A `period` of 0 acts as 1.
- R3: With mode 1 (dispatch mode), each dispatch counts one. The dispatch that completes the `period`-th count is not tracked. The next dispatch, on a later edge, is tracked.
- R4: A retire strobe whose tag equals the tracked tag sets `smpValid` on the next edge and makes `irq` high for exactly that one cycle. A retire of any other tag has no effect.
- R5: The sample holds the address, timestamp and process identifier given with the tracked dispatch. Its flag field is the OR of all `evtFlags` whose `evtTag` equals the tracked tag, from the edge after the capture up to and including the retire edge.
- R6: In cycle mode, if the period runs out while no dispatch is present, the unit keeps waiting for as many cycles as it takes. The first dispatch after that is tracked.
- R7: A flush strobe for the tracked tag drops the operation. It produces no sample and no `irq`, and counting restarts from zero. A flush of any other tag has no effect. If a flush and a retire of the tracked tag arrive together, the flush wins.
- R8: Once a sample is held, no further operation is tracked. The sample fields and `smpValid` stay unchanged until `clearSample`. After `clearSample`, `smpValid` reads 0 on the next cycle and counting restarts from zero.
- R9: `modeSel` (0 = cycles, 1 = dispatches) is taken into the unit only on edges where `enable` is low. Changes while enabled have no effect.
- R10: Lowering `enable` while no sample is held abandons any pending or tracked operation and resets the counter. A later retire of the abandoned tag produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable |
| modeSel | input | 1 | Selection basis: 0 cycles, 1 dispatched ops |
| period | input | CNT_W | Sampling period |
| clearSample | input | 1 | Releases a held sample and re-arms the unit |
| dispValid | input | 1 | Dispatch strobe |
| dispTag | input | TAG_W | Tag of the dispatched op |
| dispAddr | input | ADDR_W | Virtual address of the originating instruction |
| dispTime | input | TS_W | Timestamp at dispatch |
| dispPid | input | PID_W | Process identifier |
| evtValid | input | 1 | Execution event strobe |
| evtTag | input | TAG_W | Tag the event belongs to |
| evtFlags | input | FLAG_W | Event flag bits |
| retValid | input | 1 | Retire strobe |
| retTag | input | TAG_W | Tag of the retiring op |
| flushValid | input | 1 | Flush strobe |
| flushTag | input | TAG_W | Tag of the squashed op |
| smpValid | output | 1 | A sample is held |
| smpAddr | output | ADDR_W | Sampled instruction address |
| smpTime | output | TS_W | Sampled timestamp |
| smpPid | output | PID_W | Sampled process identifier |
| smpFlags | output | FLAG_W | Accumulated event flags |
| irq | output | 1 | One-cycle sampling interrupt |

## Verification
The bench first checks which operation gets picked. In cycle mode with gaps between dispatches, the third op should be picked. In dispatch mode the fifth op should be picked. A design that counted on the wrong basis, or that followed a `modeSel` change while enabled, picks a different op and reports the wrong address. A pending tag is held through ten idle cycles; a design that let the pending condition lapse would never produce that sample. The bench also flushes the tracked op, disables the unit mid-flight and keeps retiring ops while a sample is held. Any of these that raises a stray interrupt, or overwrites a held record, shows up as an unexpected scoreboard item or a changed address. A design that accepts events for the wrong tag, or drops events after capture, gives a wrong flag field.

// File: rtl/sampler_pkg.sv
`timescale 1ns/1ps
package sampler_pkg;

  typedef enum logic [1:0] {
    ST_COUNT,
    ST_PEND,
    ST_TRACK,
    ST_HOLD
  } smpState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic accum;
    logic publish;
    logic clear;
  } dpStrobe_t;

  // datapath -> control tag matches
  typedef struct packed {
    logic evtHit;
    logic retHit;
    logic flushHit;
  } dpHit_t;

endpackage

// File: rtl/sampler_ctrl.sv
`timescale 1ns/1ps
module sampler_ctrl
  import sampler_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             modeSel,
  input  logic [CNT_W-1:0] period,
  input  logic             clearSample,
  input  logic             dispValid,
  input  dpHit_t           hits,
  output dpStrobe_t        strobe,
  output logic             tracking,
  output logic             modeQ
);

  localparam int W1 = CNT_W + 1;

  smpState_t        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic [W1-1:0]    cntPlus;
  logic             tick;
  logic             reach;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 1'b0;
    else if (!enable) modeQ <= modeSel;
  end

  assign tick    = modeQ ? dispValid : 1'b1;
  assign cntPlus = {1'b0, cntQ} + W1'(1);
  assign reach   = cntPlus >= {1'b0, period};

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    strobe = '0;
    if (stateQ == ST_HOLD) begin
      if (clearSample) begin
        strobe.clear = 1'b1;
        stateD       = ST_COUNT;
        cntD         = '0;
      end
    end else if (!enable) begin
      stateD = ST_COUNT;
      cntD   = '0;
    end else begin
      case (stateQ)
        ST_COUNT: begin
          if (tick) begin
            if (reach) begin
              stateD = ST_PEND;
              cntD   = '0;
            end else begin
              cntD = cntPlus[CNT_W-1:0];
            end
          end
        end
        ST_PEND: begin
          if (dispValid) begin
            strobe.capture = 1'b1;
            stateD         = ST_TRACK;
          end
        end
        ST_TRACK: begin
          if (hits.flushHit) begin
            stateD = ST_COUNT;
            cntD   = '0;
          end else begin
            strobe.accum = hits.evtHit;
            if (hits.retHit) begin
              strobe.publish = 1'b1;
              stateD         = ST_HOLD;
            end
          end
        end
        default: stateD = ST_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_COUNT;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign tracking = (stateQ == ST_TRACK);

endmodule

// File: rtl/sampler_dp.sv
`timescale 1ns/1ps
module sampler_dp
  import sampler_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 48,
  parameter int TS_W   = 32,
  parameter int PID_W  = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [TAG_W-1:0]  dispTag,
  input  logic [ADDR_W-1:0] dispAddr,
  input  logic [TS_W-1:0]   dispTime,
  input  logic [PID_W-1:0]  dispPid,
  input  logic              evtValid,
  input  logic [TAG_W-1:0]  evtTag,
  input  logic [FLAG_W-1:0] evtFlags,
  input  logic              retValid,
  input  logic [TAG_W-1:0]  retTag,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushTag,
  output dpHit_t            hits,
  output logic [TAG_W-1:0]  tagQ,
  output logic              validQ,
  output logic              irqQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [TS_W-1:0]   timeQ,
  output logic [PID_W-1:0]  pidQ,
  output logic [FLAG_W-1:0] flagsQ
);

  logic [FLAG_W-1:0] evtMasked;

  assign hits.evtHit   = evtValid   && (evtTag   == tagQ);
  assign hits.retHit   = retValid   && (retTag   == tagQ);
  assign hits.flushHit = flushValid && (flushTag == tagQ);

  assign evtMasked = hits.evtHit ? evtFlags : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ   <= '0;
      addrQ  <= '0;
      timeQ  <= '0;
      pidQ   <= '0;
      flagsQ <= '0;
    end else if (strobe.capture) begin
      tagQ   <= dispTag;
      addrQ  <= dispAddr;
      timeQ  <= dispTime;
      pidQ   <= dispPid;
      flagsQ <= '0;
    end else if (strobe.accum) begin
      flagsQ <= flagsQ | evtMasked;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      irqQ <= strobe.publish;
      if (strobe.publish) validQ <= 1'b1;
      else if (strobe.clear) validQ <= 1'b0;
    end
  end

endmodule

// File: rtl/op_retire_sampler.sv
`timescale 1ns/1ps
module op_retire_sampler
  import sampler_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 48,
  parameter int TS_W   = 32,
  parameter int PID_W  = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              modeSel,
  input  logic [CNT_W-1:0]  period,
  input  logic              clearSample,
  input  logic              dispValid,
  input  logic [TAG_W-1:0]  dispTag,
  input  logic [ADDR_W-1:0] dispAddr,
  input  logic [TS_W-1:0]   dispTime,
  input  logic [PID_W-1:0]  dispPid,
  input  logic              evtValid,
  input  logic [TAG_W-1:0]  evtTag,
  input  logic [FLAG_W-1:0] evtFlags,
  input  logic              retValid,
  input  logic [TAG_W-1:0]  retTag,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushTag,
  output logic              smpValid,
  output logic [ADDR_W-1:0] smpAddr,
  output logic [TS_W-1:0]   smpTime,
  output logic [PID_W-1:0]  smpPid,
  output logic [FLAG_W-1:0] smpFlags,
  output logic              irq
);

  dpStrobe_t        strobe;
  dpHit_t           hits;
  logic             tracking;
  logic             modeQ;
  logic [TAG_W-1:0] tagQ;

  sampler_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .modeSel     (modeSel),
    .period      (period),
    .clearSample (clearSample),
    .dispValid   (dispValid),
    .hits        (hits),
    .strobe      (strobe),
    .tracking    (tracking),
    .modeQ       (modeQ)
  );

  sampler_dp #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .PID_W(PID_W), .FLAG_W(FLAG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dispTag    (dispTag),
    .dispAddr   (dispAddr),
    .dispTime   (dispTime),
    .dispPid    (dispPid),
    .evtValid   (evtValid),
    .evtTag     (evtTag),
    .evtFlags   (evtFlags),
    .retValid   (retValid),
    .retTag     (retTag),
    .flushValid (flushValid),
    .flushTag   (flushTag),
    .hits       (hits),
    .tagQ       (tagQ),
    .validQ     (smpValid),
    .irqQ       (irq),
    .addrQ      (smpAddr),
    .timeQ      (smpTime),
    .pidQ       (smpPid),
    .flagsQ     (smpFlags)
  );

endmodule

// File: rtl/sampler_checks.sv
`timescale 1ns/1ps
module sampler_checks #(
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 48,
  parameter int TS_W   = 32,
  parameter int PID_W  = 16,
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              clearSample,
  input logic              retValid,
  input logic              flushValid,
  input logic [TAG_W-1:0]  flushTag,
  input logic              irq,
  input logic              smpValid,
  input logic [ADDR_W-1:0] smpAddr,
  input logic [TS_W-1:0]   smpTime,
  input logic [PID_W-1:0]  smpPid,
  input logic [FLAG_W-1:0] smpFlags,
  input logic              modeQ,
  input logic              tracking,
  input logic [TAG_W-1:0]  tagQ
);

  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  a_r4_irq_after_retire: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(retValid));

  a_r4_irq_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> smpValid);

  a_r8_sample_held: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && !clearSample) |=> (smpValid && $stable(smpAddr) && $stable(smpTime)
                                    && $stable(smpPid) && $stable(smpFlags)));

  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> $stable(modeQ));

  a_r7_flush_silent: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && flushValid && (flushTag == tagQ)) |=> !irq);

endmodule

bind op_retire_sampler sampler_checks #(
  .TAG_W(TAG_W), .ADDR_W(ADDR_W), .TS_W(TS_W), .PID_W(PID_W), .FLAG_W(FLAG_W)
) u_checks (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .clearSample (clearSample),
  .retValid    (retValid),
  .flushValid  (flushValid),
  .flushTag    (flushTag),
  .irq         (irq),
  .smpValid    (smpValid),
  .smpAddr     (smpAddr),
  .smpTime     (smpTime),
  .smpPid      (smpPid),
  .smpFlags    (smpFlags),
  .modeQ       (modeQ),
  .tracking    (tracking),
  .tagQ        (tagQ)
);

// File: tb/test_op_retire_sampler.sv
`timescale 1ns/1ps
module test_op_retire_sampler;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable, modeSel, clearSample;
  logic [15:0] period;
  logic        dispValid;
  logic [5:0]  dispTag;
  logic [47:0] dispAddr;
  logic [31:0] dispTime;
  logic [15:0] dispPid;
  logic        evtValid;
  logic [5:0]  evtTag;
  logic [7:0]  evtFlags;
  logic        retValid;
  logic [5:0]  retTag;
  logic        flushValid;
  logic [5:0]  flushTag;
  logic        smpValid;
  logic [47:0] smpAddr;
  logic [31:0] smpTime;
  logic [15:0] smpPid;
  logic [7:0]  smpFlags;
  logic        irq;

  always #2.5 clk = ~clk;

  op_retire_sampler i_op_retire_sampler (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel), .period(period),
    .clearSample(clearSample), .dispValid(dispValid), .dispTag(dispTag),
    .dispAddr(dispAddr), .dispTime(dispTime), .dispPid(dispPid),
    .evtValid(evtValid), .evtTag(evtTag), .evtFlags(evtFlags),
    .retValid(retValid), .retTag(retTag), .flushValid(flushValid), .flushTag(flushTag),
    .smpValid(smpValid), .smpAddr(smpAddr), .smpTime(smpTime), .smpPid(smpPid),
    .smpFlags(smpFlags), .irq(irq)
  );

  typedef struct {
    logic [47:0] addr;
    logic [31:0] ts;
    logic [15:0] pid;
    logic [7:0]  flags;
  } expItem_t;

  expItem_t sbQ[$];
  int nChecks = 0;
  int nErrors = 0;
  int irqCount = 0;
  bit done = 1'b0;
  logic prevIrq = 1'b0;

  function automatic logic [47:0] opAddr(int k, int r);
    return 48'h4000_0000 + 48'(r) * 48'h1000 + 48'(k) * 48'd4;
  endfunction
  function automatic logic [31:0] opTime(int k, int r);
    return 32'(1000 * r + k);
  endfunction
  function automatic logic [15:0] opPid(int r);
    return 16'h50 + 16'(r);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic expectSample(int k, int r, logic [7:0] f);
    expItem_t it;
    it.addr = opAddr(k, r);
    it.ts = opTime(k, r);
    it.pid = opPid(r);
    it.flags = f;
    sbQ.push_back(it);
  endtask

  // monitor: compares each interrupt against the scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (irq && prevIrq) check(1'b0, "R4", "irq longer than one cycle", 1, 0);
      if (irq) begin
        irqCount++;
        if (sbQ.size() == 0) begin
          check(1'b0, "R4", "unexpected sample irq", 1, 0);
        end else begin
          expItem_t e;
          e = sbQ.pop_front();
          check(smpValid == 1'b1, "R4", "smpValid with irq", longint'(smpValid), 1);
          check(smpAddr == e.addr, "R5", "sample address", longint'(smpAddr), longint'(e.addr));
          check(smpTime == e.ts, "R5", "sample timestamp", longint'(smpTime), longint'(e.ts));
          check(smpPid == e.pid, "R5", "sample pid", longint'(smpPid), longint'(e.pid));
          check(smpFlags == e.flags, "R5", "sample flags", longint'(smpFlags), longint'(e.flags));
        end
      end
      prevIrq = irq;
    end
  end

  task automatic dispatchRun(int first, int last, int gap, int r);
    for (int k = first; k <= last; k++) begin
      dispValid = 1'b1;
      dispTag = 6'(k);
      dispAddr = opAddr(k, r);
      dispTime = opTime(k, r);
      dispPid = opPid(r);
      @(negedge clk);
      dispValid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic sendEvt(int tag, logic [7:0] f);
    evtValid = 1'b1; evtTag = 6'(tag); evtFlags = f;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic retire(int tag);
    retValid = 1'b1; retTag = 6'(tag);
    @(negedge clk);
    retValid = 1'b0;
  endtask

  task automatic flush(int tag);
    flushValid = 1'b1; flushTag = 6'(tag);
    @(negedge clk);
    flushValid = 1'b0;
  endtask

  task automatic enableWith(logic m, int p);
    modeSel = m;
    period = 16'(p);
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic reArm();
    enable = 1'b0;
    clearSample = 1'b1;
    @(negedge clk);
    clearSample = 1'b0;
    check(smpValid == 1'b0, "R8", "smpValid after clear", longint'(smpValid), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; modeSel = 1'b0; clearSample = 1'b0; period = 16'd4;
    dispValid = 1'b0; dispTag = '0; dispAddr = '0; dispTime = '0; dispPid = '0;
    evtValid = 1'b0; evtTag = '0; evtFlags = '0;
    retValid = 1'b0; retTag = '0; flushValid = 1'b0; flushTag = '0;
    repeat (3) @(negedge clk);
    check(smpValid == 1'b0, "R1", "smpValid in reset", longint'(smpValid), 0);
    check(irq == 1'b0, "R1", "irq in reset", longint'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(smpValid == 1'b0, "R1", "smpValid after reset", longint'(smpValid), 0);

    // R2 cycle mode, back-to-back dispatch: op 5 tracked; R5 flag OR by tag
    enableWith(1'b0, 4);
    dispatchRun(1, 6, 0, 1);
    sendEvt(3, 8'h80);
    sendEvt(5, 8'h01);
    sendEvt(5, 8'h04);
    expectSample(5, 1, 8'h05);
    for (int k = 1; k <= 6; k++) retire(k);
    @(negedge clk);
    check(smpValid == 1'b1, "R4", "smpValid held after retire", longint'(smpValid), 1);
    check(irqCount == 1, "R2", "samples after cycle-mode run", irqCount, 1);

    // R8 disarmed while a sample is held
    dispatchRun(7, 12, 0, 1);
    for (int k = 7; k <= 12; k++) retire(k);
    @(negedge clk);
    check(smpAddr == opAddr(5, 1), "R8", "held address unchanged", longint'(smpAddr), longint'(opAddr(5, 1)));
    check(irqCount == 1, "R8", "no new sample while held", irqCount, 1);
    reArm();

    // R3 dispatch mode with gaps, R9 mode change while enabled ignored
    enableWith(1'b1, 4);
    modeSel = 1'b0;
    dispatchRun(1, 5, 1, 2);
    sendEvt(5, 8'h10);
    expectSample(5, 2, 8'h10);
    for (int k = 1; k <= 5; k++) retire(k);
    @(negedge clk);
    check(irqCount == 2, "R3", "dispatch-mode sample count", irqCount, 2);
    reArm();

    // R2 cycle mode with gaps picks op 3, R9 flip to dispatch ignored
    enableWith(1'b0, 4);
    modeSel = 1'b1;
    dispatchRun(1, 5, 1, 3);
    expectSample(3, 3, 8'h00);
    for (int k = 1; k <= 5; k++) retire(k);
    @(negedge clk);
    check(irqCount == 3, "R9", "cycle-mode gap sample count", irqCount, 3);
    reArm();

    // R6 pending condition held through idle cycles
    enableWith(1'b0, 4);
    repeat (10) @(negedge clk);
    check(smpValid == 1'b0, "R6", "no sample before dispatch", longint'(smpValid), 0);
    dispatchRun(1, 1, 0, 4);
    expectSample(1, 4, 8'h00);
    retire(1);
    @(negedge clk);
    check(irqCount == 4, "R6", "late dispatch sampled", irqCount, 4);
    reArm();

    // R7 flush of tracked op, then restart
    enableWith(1'b1, 3);
    dispatchRun(1, 4, 0, 5);
    flush(2);
    flush(4);
    retire(4);
    @(negedge clk);
    check(smpValid == 1'b0, "R7", "no sample after flush", longint'(smpValid), 0);
    check(irqCount == 4, "R7", "no irq after flush", irqCount, 4);
    dispatchRun(5, 8, 0, 5);
    sendEvt(8, 8'h20);
    sendEvt(8, 8'h02);
    expectSample(8, 5, 8'h22);
    retire(8);
    @(negedge clk);
    check(irqCount == 5, "R7", "sample after flush restart", irqCount, 5);
    reArm();

    // R10 disabling abandons the tracked op and resets the counter
    enableWith(1'b1, 2);
    dispatchRun(1, 3, 0, 6);
    enable = 1'b0;
    @(negedge clk);
    retire(3);
    @(negedge clk);
    check(smpValid == 1'b0, "R10", "abandoned op gives no sample", longint'(smpValid), 0);
    enable = 1'b1;
    dispatchRun(4, 6, 0, 6);
    expectSample(6, 6, 8'h00);
    retire(6);
    @(negedge clk);
    check(irqCount == 6, "R10", "sample after re-enable", irqCount, 6);

    check(sbQ.size() == 0, "R4", "scoreboard drained", sbQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule